// File: doc/BRIEF.md
# Dual 8-bit Interval Timer with Pulse and PWM Modes

This block holds two 8-bit up-counters, each with its own compare register. A shared two-bit mode field turns the pair into one of four machines: two independent interval timers, one 16-bit interval timer built from both counters, a programmable pulse generator that places both edges of a pulse inside one period, or a pulse-width modulator on the first counter with a selectable period of 64, 128 or 256 counts. Counting advances only on clock-enable ticks that an external prescaler supplies. There is one tick input for each channel.

Software reaches the block through a small write port with four registers. Address 0 holds the configuration, address 1 the first compare value, address 2 the second compare value, and address 3 the control of the output flip-flop. Each channel has a one-cycle match interrupt. A single flip-flop drives the timer output. It can be forced high or low by a register command, or left to change automatically on compare events. The first compare register can be double-buffered, so that a new PWM or pulse setting takes effect only at a period boundary.

Top module: `tmr_pair`

## Requirements
- R1: After reset, `irq0`, `irq1` and `timerOut` are 0, every register field is 0, and both counters are 0. A channel started right after reset with compare value C raises its first match C+1 ticks later.
- R2: Configuration register (address 0) layout: bits 1:0 mode (00 split, 01 wide, 10 pulse, 11 PWM), bit 2 run0, bit 3 run1, bit 4 chain, bit 5 buffer enable, bits 7:6 PWM size. In split mode, a running channel whose counter equals its compare value C on a tick clears to 0 and pulses its interrupt for one cycle, so matches repeat every C+1 ticks. Channel 0 uses `tick0` and channel 1 uses `tick1` when chain is 0.
- R3: In split mode with chain = 1, channel 1 counts channel 0's match events instead of `tick1`, so `irq1` repeats every (C0+1)·(C1+1) ticks of `tick0`.
- R4: In wide mode (01), the counters form one 16-bit counter {cnt1,cnt0} that counts on `tick0` under run0. It matches against {cmp1,cmp0}, clears on a full 16-bit match, and pulses only `irq1`. `irq0` stays 0.
- R5: In pulse mode (10) with output auto-update enabled, counter 0 runs from 0 up to cmp1 and clears there. The output inverts when the counter matches cmp0 and again at the cmp1 period end. A match on cmp0 does not clear the counter. With cmp0 < cmp1 the output is high for cmp1−cmp0 ticks and low for cmp0+1 ticks.
- R6: In PWM mode (11), counter 0 wraps at 2^n−1, with n = 6, 7 or 8 for PWM size 00, 01 or 1x. The output clears at the wrap and sets when the counter matches cmp0. The result is cmp0+1 ticks low and 2^n−1−cmp0 ticks high.
- R7: While a channel's run bit is 0, its counter is held at 0 and its interrupt stays quiet. Setting the run bit again starts counting from 0.
- R8: With the buffer enable bit set in pulse or PWM mode, a write to cmp0 (address 1) is held in a buffer. It becomes active at the next PWM wrap or pulse period end. With the bit clear, or in split or wide mode, the write takes effect at once.
- R9: Output control register (address 3) layout: bit 0 auto-update enable, bit 1 toggle source in split mode (0 channel 0 match, 1 channel 1 match), bits 3:2 command (01 set, 10 clear). A command changes `timerOut` on the write edge. With auto-update disabled, compare events leave `timerOut` unchanged. In split mode with auto-update enabled, `timerOut` toggles on each match of the selected channel.
- R10: A running counter changes only on cycles where its tick input is 1. At half tick rate, the match period doubles in clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tick0 | input | 1 | Count enable for channel 0 from the prescaler |
| tick1 | input | 1 | Count enable for channel 1 from the prescaler |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register address |
| wrData | input | 8 | Register write data |
| irq0 | output | 1 | Channel 0 match or wrap interrupt, one-cycle pulse |
| irq1 | output | 1 | Channel 1 match or period-end interrupt, one-cycle pulse |
| timerOut | output | 1 | Output flip-flop |

## Verification
The bench measures interval periods, pulse widths and PWM high and low runs in clock cycles, and compares them with counts derived from the compare values. An off-by-one in the clear-on-match path, or a pulse counter that also clears on cmp0, changes these counts. The double-buffer test writes a new duty value while the counter is stopped. A design that loads the value at once instead of at the wrap shows the new low width in the first period instead of the second. Other tests restart a channel after a stop, halve the tick rate, chain channel 1 onto channel 0's matches, and check that wide mode leaves `irq0` silent. A stop that does not clear the counter, a tick that is ignored, or a cascade that counts raw ticks each gives a period different from the expected one.

// File: rtl/tmr_pair_pkg.sv
package tmr_pair_pkg;

  typedef enum logic [1:0] {
    MODE_SPLIT = 2'b00,
    MODE_WIDE  = 2'b01,
    MODE_PULSE = 2'b10,
    MODE_PWM   = 2'b11
  } tmrMode_e;

  typedef struct packed {
    logic [1:0] pwmSize;
    logic       bufEn;
    logic       chain;
    logic       run1;
    logic       run0;
    tmrMode_e   mode;
    logic       outEn;
    logic       outSel;
  } tmrCfg_t;

  typedef struct packed {
    logic clr0;
    logic inc0;
    logic clr1;
    logic inc1;
    logic wrCmp0;
    logic wrCmp1;
    logic cmpDirect;
    logic loadCmp0;
    logic ffSet;
    logic ffClr;
    logic ffTgl;
  } tmrStrobe_t;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_CMP0 = 2'd1;
  localparam logic [1:0] ADDR_CMP1 = 2'd2;
  localparam logic [1:0] ADDR_OUT  = 2'd3;

  localparam logic [1:0] CMD_SET = 2'b01;
  localparam logic [1:0] CMD_CLR = 2'b10;

endpackage

// File: rtl/tmr_pair_cnt.sv
module tmr_pair_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)    cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/tmr_pair_dp.sv
module tmr_pair_dp
  import tmr_pair_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       st,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       pwmSize,
  output logic [CNT_W-1:0] cnt0,
  output logic [CNT_W-1:0] cnt1,
  output logic             hitA,
  output logic             hitB,
  output logic             hitC,
  output logic             hitWide,
  output logic             lowMax,
  output logic             pwmTop,
  output logic             ffQ
);

  localparam int NCH = 2;

  logic [CNT_W-1:0] cntArr [NCH];
  logic [NCH-1:0]   clrV;
  logic [NCH-1:0]   incV;
  logic [CNT_W-1:0] cmp0Act, cmp0Buf, cmp1Q;
  logic [CNT_W-1:0] topVal;

  assign clrV = {st.clr1, st.clr0};
  assign incV = {st.inc1, st.inc0};

  for (genvar g = 0; g < NCH; g++) begin : gCh
    tmr_pair_cnt #(.CNT_W(CNT_W)) cnt_i (
      .clk (clk),
      .rstN(rstN),
      .clr (clrV[g]),
      .inc (incV[g]),
      .cnt (cntArr[g])
    );
  end

  assign cnt0 = cntArr[0];
  assign cnt1 = cntArr[1];

  // compare registers: cmp0 has a staging buffer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmp0Act <= '0;
      cmp0Buf <= '0;
      cmp1Q   <= '0;
    end else begin
      if (st.wrCmp0) cmp0Buf <= wrData;
      if (st.wrCmp0 && st.cmpDirect) cmp0Act <= wrData;
      else if (st.loadCmp0)          cmp0Act <= cmp0Buf;
      if (st.wrCmp1) cmp1Q <= wrData;
    end
  end

  always_comb begin
    case (pwmSize)
      2'b00:   topVal = {CNT_W{1'b1}} >> 2;
      2'b01:   topVal = {CNT_W{1'b1}} >> 1;
      default: topVal = {CNT_W{1'b1}};
    endcase
  end

  assign hitA    = (cnt0 == cmp0Act);
  assign hitB    = (cnt0 == cmp1Q);
  assign hitC    = (cnt1 == cmp1Q);
  assign hitWide = ({cnt1, cnt0} == {cmp1Q, cmp0Act});
  assign lowMax  = (cnt0 == {CNT_W{1'b1}});
  assign pwmTop  = (cnt0 == topVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         ffQ <= 1'b0;
    else if (st.ffSet) ffQ <= 1'b1;
    else if (st.ffClr) ffQ <= 1'b0;
    else if (st.ffTgl) ffQ <= ~ffQ;
  end

endmodule

// File: rtl/tmr_pair_ctl.sv
module tmr_pair_ctl
  import tmr_pair_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick0,
  input  logic             tick1,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  input  logic             hitA,
  input  logic             hitB,
  input  logic             hitC,
  input  logic             hitWide,
  input  logic             lowMax,
  input  logic             pwmTop,
  output tmrCfg_t          cfg,
  output tmrStrobe_t       st,
  output logic             irq0,
  output logic             irq1
);

  logic step0, step1, match0, match1, wideHit, periodEnd, ovf;
  logic irq0N, irq1N, autoTgl, autoSet, autoClr;
  logic swSet, swClr, wrOut;

  assign wrOut = wrEn && (wrAddr == ADDR_OUT);
  assign swSet = wrOut && (wrData[3:2] == CMD_SET);
  assign swClr = wrOut && (wrData[3:2] == CMD_CLR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrEn) begin
      if (wrAddr == ADDR_CFG) begin
        cfg.mode    <= tmrMode_e'(wrData[1:0]);
        cfg.run0    <= wrData[2];
        cfg.run1    <= wrData[3];
        cfg.chain   <= wrData[4];
        cfg.bufEn   <= wrData[5];
        cfg.pwmSize <= wrData[7:6];
      end
      if (wrAddr == ADDR_OUT) begin
        cfg.outEn  <= wrData[0];
        cfg.outSel <= wrData[1];
      end
    end
  end

  always_comb begin
    st        = '0;
    irq0N     = 1'b0;
    irq1N     = 1'b0;
    autoTgl   = 1'b0;
    autoSet   = 1'b0;
    autoClr   = 1'b0;
    step1     = 1'b0;
    match0    = 1'b0;
    match1    = 1'b0;
    wideHit   = 1'b0;
    periodEnd = 1'b0;
    ovf       = 1'b0;
    step0     = tick0 & cfg.run0;

    case (cfg.mode)
      MODE_SPLIT: begin
        match0  = step0 & hitA;
        step1   = cfg.run1 & (cfg.chain ? match0 : tick1);
        match1  = step1 & hitC;
        st.clr0 = ~cfg.run0 | match0;
        st.inc0 = step0 & ~hitA;
        st.clr1 = ~cfg.run1 | match1;
        st.inc1 = step1 & ~hitC;
        irq0N   = match0;
        irq1N   = match1;
        autoTgl = cfg.outSel ? match1 : match0;
      end
      MODE_WIDE: begin
        wideHit = step0 & hitWide;
        st.clr0 = ~cfg.run0 | wideHit;
        st.clr1 = ~cfg.run0 | wideHit;
        st.inc0 = step0 & ~hitWide;
        st.inc1 = step0 & ~hitWide & lowMax;
        irq1N   = wideHit;
        autoTgl = wideHit;
      end
      MODE_PULSE: begin
        periodEnd   = step0 & hitB;
        st.clr0     = ~cfg.run0 | periodEnd;
        st.inc0     = step0 & ~hitB;
        st.clr1     = 1'b1;
        st.loadCmp0 = periodEnd & cfg.bufEn;
        irq0N       = step0 & hitA;
        irq1N       = periodEnd;
        autoTgl     = periodEnd | (step0 & hitA);
      end
      MODE_PWM: begin
        ovf         = step0 & pwmTop;
        st.clr0     = ~cfg.run0 | ovf;
        st.inc0     = step0 & ~pwmTop;
        st.clr1     = 1'b1;
        st.loadCmp0 = ovf & cfg.bufEn;
        irq0N       = ovf;
        autoSet     = step0 & hitA & ~pwmTop;
        autoClr     = ovf;
      end
    endcase

    st.wrCmp0    = wrEn && (wrAddr == ADDR_CMP0);
    st.wrCmp1    = wrEn && (wrAddr == ADDR_CMP1);
    st.cmpDirect = ~cfg.bufEn | ~cfg.mode[1];

    // a software command overrides any automatic change in the same cycle
    st.ffSet = swSet | (~swClr & ~swSet & cfg.outEn & autoSet);
    st.ffClr = swClr | (~swSet & ~swClr & cfg.outEn & autoClr);
    st.ffTgl = ~swSet & ~swClr & cfg.outEn & autoTgl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
    end else begin
      irq0 <= irq0N;
      irq1 <= irq1N;
    end
  end

endmodule

// File: rtl/tmr_pair.sv
module tmr_pair
  import tmr_pair_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick0,
  input  logic             tick1,
  input  logic             wrEn,
  input  logic [1:0]       wrAddr,
  input  logic [CNT_W-1:0] wrData,
  output logic             irq0,
  output logic             irq1,
  output logic             timerOut
);

  tmrCfg_t          cfg;
  tmrStrobe_t       st;
  logic [CNT_W-1:0] cnt0, cnt1;
  logic hitA, hitB, hitC, hitWide, lowMax, pwmTop;

  tmr_pair_ctl #(.CNT_W(CNT_W)) ctl_i (
    .clk    (clk),
    .rstN   (rstN),
    .tick0  (tick0),
    .tick1  (tick1),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .hitA   (hitA),
    .hitB   (hitB),
    .hitC   (hitC),
    .hitWide(hitWide),
    .lowMax (lowMax),
    .pwmTop (pwmTop),
    .cfg    (cfg),
    .st     (st),
    .irq0   (irq0),
    .irq1   (irq1)
  );

  tmr_pair_dp #(.CNT_W(CNT_W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .wrData (wrData),
    .pwmSize(cfg.pwmSize),
    .cnt0   (cnt0),
    .cnt1   (cnt1),
    .hitA   (hitA),
    .hitB   (hitB),
    .hitC   (hitC),
    .hitWide(hitWide),
    .lowMax (lowMax),
    .pwmTop (pwmTop),
    .ffQ    (timerOut)
  );

endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       mode,
  input logic             run0,
  input logic             tick0,
  input logic [CNT_W-1:0] cnt0,
  input logic [CNT_W-1:0] cnt1,
  input logic             irq0
);

  // R7: a stopped channel 0 is cleared on the next edge
  a_r7_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    !run0 |=> (cnt0 == '0));

  // R10: without a tick a running counter holds its value
  a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rstN)
    (run0 && !tick0) |=> $stable(cnt0));

  // R4: wide mode never raises the channel 0 interrupt
  a_r4_wide_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'b01 && $past(mode) == 2'b01) |-> !irq0);

  // R5 / R6: the second counter stays idle in pulse and PWM modes
  a_r5_ch1_idle: assert property (@(posedge clk) disable iff (!rstN)
    mode[1] |=> (cnt1 == '0));

  // R2: an interrupt on channel 0 follows a cycle with the channel running
  a_r2_irq_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    irq0 |-> $past(run0));

endmodule

bind tmr_pair tmr_pair_chk #(.CNT_W(CNT_W)) chk_i (
  .clk  (clk),
  .rstN (rstN),
  .mode (cfg.mode),
  .run0 (cfg.run0),
  .tick0(tick0),
  .cnt0 (cnt0),
  .cnt1 (cnt1),
  .irq0 (irq0)
);

// File: tb/tmr_pair_tb_top.sv
module tmr_pair_tb_top;

  localparam int W     = 8;
  localparam int LIMIT = 2000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick0 = 1'b1;
  logic tick1 = 1'b1;
  logic wrEn = 1'b0;
  logic [1:0] wrAddr = '0;
  logic [W-1:0] wrData = '0;
  logic irq0, irq1, timerOut;
  logic halfRate = 1'b0;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  tmr_pair #(.CNT_W(W)) dut_i (
    .clk(clk), .rstN(rstN), .tick0(tick0), .tick1(tick1),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .irq0(irq0), .irq1(irq1), .timerOut(timerOut)
  );

  // kind: 0 irq0 period, 1 irq1 period, 2 output high/low runs
  typedef struct packed {
    logic [1:0]  mode;
    logic        chain;
    logic [1:0]  size;
    logic [7:0]  c0;
    logic [7:0]  c1;
    logic [1:0]  outCtl;
    logic [1:0]  kind;
    logic [15:0] expA;
    logic [15:0] expB;
    logic [3:0]  req;
  } row_t;

  localparam row_t ROWS [0:10] = '{
    '{2'd0, 1'b0, 2'd0, 8'd9,   8'd0, 2'd0, 2'd0, 16'd10,  16'hFFFF, 4'd2}, // R2 channel 0
    '{2'd0, 1'b0, 2'd0, 8'd0,   8'd5, 2'd0, 2'd1, 16'd6,   16'hFFFF, 4'd2}, // R2 channel 1
    '{2'd0, 1'b1, 2'd0, 8'd3,   8'd2, 2'd0, 2'd1, 16'd12,  16'hFFFF, 4'd3}, // R3 chained
    '{2'd1, 1'b0, 2'd0, 8'h2C,  8'd1, 2'd0, 2'd1, 16'd301, 16'd0,    4'd4}, // R4 wide
    '{2'd2, 1'b0, 2'd0, 8'd4,   8'd10,2'd1, 2'd2, 16'd6,   16'd5,    4'd5}, // R5 pulse
    '{2'd2, 1'b0, 2'd0, 8'd0,   8'd7, 2'd1, 2'd2, 16'd7,   16'd1,    4'd5}, // R5 early edge
    '{2'd3, 1'b0, 2'd2, 8'd64,  8'd0, 2'd1, 2'd2, 16'd191, 16'd65,   4'd6}, // R6 8-bit
    '{2'd3, 1'b0, 2'd0, 8'd20,  8'd0, 2'd1, 2'd2, 16'd43,  16'd21,   4'd6}, // R6 6-bit
    '{2'd3, 1'b0, 2'd1, 8'd100, 8'd0, 2'd1, 2'd2, 16'd27,  16'd101,  4'd6}, // R6 7-bit
    '{2'd0, 1'b0, 2'd0, 8'd4,   8'd0, 2'd1, 2'd2, 16'd5,   16'd5,    4'd9}, // R9 toggle ch0
    '{2'd0, 1'b0, 2'd0, 8'd0,   8'd2, 2'd3, 2'd2, 16'd3,   16'd3,    4'd9}  // R9 toggle ch1
  };

  function automatic logic [7:0] cfgByte(input logic [1:0] mode, input logic r0,
      input logic r1, input logic chain, input logic bufEn, input logic [1:0] size);
    return {size, bufEn, chain, r1, r0, mode};
  endfunction

  function automatic logic pick(input int which);
    case (which)
      0:       return irq0;
      1:       return irq1;
      default: return timerOut;
    endcase
  endfunction

  task automatic check(input int req, input int act, input int exp, input string what);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL R%0d %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // counts samples equal to lvl, ending on the first sample that differs
  task automatic runLen(input int which, input logic lvl, output int n);
    n = 0;
    while (pick(which) == lvl && n < LIMIT) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    tick0 = 1'b1;
    forever begin
      @(negedge clk);
      tick0 = halfRate ? ~tick0 : 1'b1;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int n, h, l, seen;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(1, irq0, 0, "irq0 after reset");
    check(1, irq1, 0, "irq1 after reset");
    check(1, timerOut, 0, "timerOut after reset");
    regWrite(2'd1, 8'd2);
    regWrite(2'd0, cfgByte(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
    runLen(0, 1'b0, n);
    check(1, n, 3, "first match after reset start");

    // R7 stop and restart
    regWrite(2'd0, 8'd0);
    regWrite(2'd1, 8'd9);
    regWrite(2'd0, cfgByte(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
    runLen(0, 1'b0, n);
    check(7, n, 10, "first match after start");
    repeat (13) @(negedge clk);
    regWrite(2'd0, 8'd0);
    seen = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (irq0) seen++;
    end
    check(7, seen, 0, "matches while stopped");
    regWrite(2'd0, cfgByte(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
    runLen(0, 1'b0, n);
    check(7, n, 10, "first match after restart");

    // R10 half-rate ticks
    regWrite(2'd0, 8'd0);
    regWrite(2'd1, 8'd3);
    halfRate = 1'b1;
    regWrite(2'd0, cfgByte(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
    runLen(0, 1'b0, n);
    runLen(0, 1'b1, h);
    runLen(0, 1'b0, l);
    check(10, h + l, 8, "period at half tick rate");
    halfRate = 1'b0;
    regWrite(2'd0, 8'd0);

    // table of mode vectors
    for (int i = 0; i < 11; i++) begin
      automatic row_t r = ROWS[i];
      regWrite(2'd0, cfgByte(r.mode, 1'b0, 1'b0, r.chain, 1'b0, r.size));
      regWrite(2'd1, r.c0);
      regWrite(2'd2, r.c1);
      regWrite(2'd3, {4'b0000, 2'b10, r.outCtl});
      regWrite(2'd0, cfgByte(r.mode, 1'b1, 1'b1, r.chain, 1'b0, r.size));
      if (r.kind == 2'd2) begin
        runLen(2, 1'b1, n);
        runLen(2, 1'b0, n);
        runLen(2, 1'b1, h);
        runLen(2, 1'b0, l);
        check(int'(r.req), h, int'(r.expA), "output high run");
        check(int'(r.req), l, int'(r.expB), "output low run");
      end else begin
        runLen(int'(r.kind), 1'b0, n);
        runLen(int'(r.kind), 1'b1, h);
        runLen(int'(r.kind), 1'b0, l);
        check(int'(r.req), h + l, int'(r.expA), "interrupt period");
        if (r.expB != 16'hFFFF) begin
          seen = 0;
          for (int k = 0; k < int'(r.expA) + 5; k++) begin
            @(negedge clk);
            if (irq0) seen++;
          end
          check(int'(r.req), seen, int'(r.expB), "irq0 pulses in wide mode");
        end
      end
    end

    // R8 buffered duty update: old value for one period, new after the wrap
    regWrite(2'd0, cfgByte(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0));
    regWrite(2'd1, 8'd10);
    regWrite(2'd0, cfgByte(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0));
    regWrite(2'd1, 8'd30);
    regWrite(2'd3, 8'b0000_1001);
    regWrite(2'd0, cfgByte(2'd3, 1'b1, 1'b0, 1'b0, 1'b1, 2'd0));
    runLen(2, 1'b0, l);
    check(8, l, 11, "first low run keeps old duty");
    runLen(2, 1'b1, h);
    check(8, h, 53, "first high run keeps old duty");
    runLen(2, 1'b0, l);
    check(8, l, 31, "low run after wrap uses new duty");

    // R8 unbuffered write takes effect at once
    regWrite(2'd0, cfgByte(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0));
    regWrite(2'd3, 8'b0000_1001);
    regWrite(2'd1, 8'd40);
    regWrite(2'd0, cfgByte(2'd3, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
    runLen(2, 1'b0, l);
    check(8, l, 41, "direct write low run");

    // R9 software commands and disabled auto-update
    regWrite(2'd0, 8'd0);
    regWrite(2'd3, 8'b0000_0100);
    check(9, timerOut, 1, "set command");
    regWrite(2'd3, 8'b0000_1000);
    check(9, timerOut, 0, "clear command");
    regWrite(2'd3, 8'b0000_0100);
    regWrite(2'd1, 8'd2);
    regWrite(2'd0, cfgByte(2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0));
    seen = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (timerOut != 1'b1) seen++;
    end
    check(9, seen, 0, "output changes with auto-update off");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule